// File: doc/BRIEF.md
# Serial PSRAM Memory-Mapped Controller

This block places a serial pseudo-static RAM in a CPU address space. A load or store to the lower part of the map becomes one framed serial transaction on a four-lane pin set. The pin set is a serial clock, an active-low select, and separate input, output and output-enable nibbles. The CPU sees an ordinary memory access that takes longer. The bus is held off with a ready signal until the serial frame has finished.

A second address window holds write-only configuration. It covers the four opcodes (read, write, enter-quad, leave-quad), the number of dummy clocks before read data, and a two-bit lane-mode register. Writes to two trigger slots in that window send the stand-alone enter-quad and leave-quad opcodes. When either sequence finishes, the quad-everything mode bit is updated to match.

A frame consists of the following, in order:
- select low
- an 8-bit opcode
- a 24-bit address, MSB first
- the programmed dummy clocks (reads only)
- 1, 2 or 4 data bytes, each MSB first, lowest address byte first
- select high

Top module: `psram_ctrl`

## Requirements
- R1: After reset, ce_n_o is 1, sck_o is 0, douten_o is 0 and bus_ready_o is 1. The read, write, enter-quad and leave-quad opcodes reset to 0x03, 0x02, 0x35 and 0xFE. The wait count and the mode register reset to 0.
- R2: Bus addresses are decoded as follows:
  - With bits [31:27] = 0, the access goes to the data window and starts a frame.
  - With bits [31:27] = 00001, the access goes to the configuration window. Writes to slots 0..5 there start no frame and complete in the acceptance cycle.
  - Reads of the configuration window start no frame.
  - Any other address starts no frame.
- R3: Single-lane frames carry out the following:
  - The opcode and the 24-bit address are sent MSB first on dout_o[0], one bit per sck rising edge.
  - Write data is sent on dout_o[0].
  - Read data is taken from din_i[1].
  - A word write takes 64 sck rising edges.
- R4: Configuration slot = bus_addr_i[4:2]. Slot 0 holds the read opcode and slot 1 the write opcode. Frames use the opcode held at the time of acceptance.
- R5: Slot 4 holds the dummy-clock count N. A read frame places N sck rising edges between the address and the first data edge. Write frames have none.
- R6: Mode register (slot 5) bit 0 selects quad data: the opcode is sent on one lane, and the address and data use four lanes, MSB nibble first. A word access takes 8+6+8 sck rising edges.
- R7: Mode bit 1 selects quad everything: the opcode, address and data all use four lanes. It takes priority over bit 0. A word write takes 16 sck rising edges.
- R8: A write to slot 6 sends the enter-quad opcode alone, on one lane (8 edges), then sets mode bit 1.
- R9: A write to slot 7 sends the leave-quad opcode alone, on four lanes (2 edges), then clears mode bit 1.
- R10: bus_ready_o is low from the edge that accepts a frame-starting access until one cycle after select rises. Each sck period spans two clocks, so a frame of B edges holds ready low for 2B+1 cycles. Read data is valid on bus_rdata_o once ready is high again.
- R11: bus_size_i 0, 1 and 2 (3 acts as 2) move 1, 2 and 4 bytes. The payload sits in the low-order bytes of bus_wdata_i and bus_rdata_o. The lowest address byte is bus data bits [7:0] and is sent first. Unused read bits are 0.
- R12: douten_o is 0001 or 1111 on the lanes in use during the opcode, address and write-data phases. It is 0000 during the dummy and read-data phases and while deselected.
- R13: sck_o stays 0 whenever ce_n_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_valid_i | input | 1 | Access request, taken when bus_ready_o is high |
| bus_write_i | input | 1 | 1 store, 0 load |
| bus_addr_i | input | 32 | Byte address |
| bus_size_i | input | 2 | 0 byte, 1 halfword, 2 word |
| bus_wdata_i | input | 32 | Store data, right-aligned |
| bus_rdata_o | output | 32 | Load data, right-aligned |
| bus_ready_o | output | 1 | Low while a serial frame is in progress |
| sck_o | output | 1 | Serial clock |
| ce_n_o | output | 1 | Memory select, active low |
| din_i | input | 4 | Serial data from memory |
| dout_o | output | 4 | Serial data to memory |
| douten_o | output | 4 | Per-lane output enable |

## Verification
Some internal faults show at the pins on the very next sck edge:
- A wrong phase counter or lane-width choice changes the number of sck edges in a frame, and the bus-ready stall length changes with it. Both are measured on every access.
- A mis-ordered shift register shows up as swapped bytes or nibbles in the memory model, or in the data read back at the end of the same frame.
- A stale mode bit after the enter-quad or leave-quad sequence is seen at the first edge of the next frame, where the opcode lanes disagree with the model.

Configuration corruption shows up only at the next frame that uses the corrupted value. The bench therefore follows each configuration write with a frame that depends on it.

// File: rtl/psram_pkg.sv
package psram_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CMD,
    PH_ADDR,
    PH_DUMMY,
    PH_DATA,
    PH_END
  } phase_e;

  localparam int unsigned NUM_OPS = 4;
  localparam logic [2:0] SLOT_RD_OP = 3'd0;
  localparam logic [2:0] SLOT_WR_OP = 3'd1;
  localparam logic [2:0] SLOT_EQ_OP = 3'd2;
  localparam logic [2:0] SLOT_XQ_OP = 3'd3;
  localparam logic [2:0] SLOT_WAIT  = 3'd4;
  localparam logic [2:0] SLOT_MODE  = 3'd5;
  localparam logic [2:0] SLOT_ENTER = 3'd6;
  localparam logic [2:0] SLOT_EXIT  = 3'd7;

  localparam logic [7:0] OP_RESET [NUM_OPS] = '{8'h03, 8'h02, 8'h35, 8'hFE};

  localparam logic [4:0] WIN_DATA = 5'b00000;
  localparam logic [4:0] WIN_CFG  = 5'b00001;

endpackage

// File: rtl/psram_cfg.sv
module psram_cfg
  import psram_pkg::*;
#(
  parameter int unsigned WAIT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [2:0]        slot_i,
  input  logic [31:0]       wdata_i,
  input  logic              qpi_set_i,
  input  logic              qpi_clr_i,
  output logic [7:0]        rd_op_o,
  output logic [7:0]        wr_op_o,
  output logic [7:0]        eq_op_o,
  output logic [7:0]        xq_op_o,
  output logic [WAIT_W-1:0] wait_o,
  output logic [1:0]        mode_o
);

  logic [7:0] op_q [NUM_OPS];

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 op_q[g] <= OP_RESET[g];
      else if (we_i && slot_i == 3'(g))            op_q[g] <= wdata_i[7:0];
    end
  end

  logic [WAIT_W-1:0] wait_q;
  logic [1:0]        mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wait_q <= '0;
      mode_q <= '0;
    end else begin
      if (we_i && slot_i == SLOT_WAIT) wait_q <= wdata_i[WAIT_W-1:0];
      if (we_i && slot_i == SLOT_MODE) mode_q <= wdata_i[1:0];
      else if (qpi_set_i)              mode_q[1] <= 1'b1;
      else if (qpi_clr_i)              mode_q[1] <= 1'b0;
    end
  end

  assign rd_op_o = op_q[SLOT_RD_OP];
  assign wr_op_o = op_q[SLOT_WR_OP];
  assign eq_op_o = op_q[SLOT_EQ_OP];
  assign xq_op_o = op_q[SLOT_XQ_OP];
  assign wait_o  = wait_q;
  assign mode_o  = mode_q;

endmodule

// File: rtl/psram_engine.sv
module psram_engine
  import psram_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned WAIT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [7:0]        op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              has_addr_i,
  input  logic              write_i,
  input  logic              cmd_wide_i,
  input  logic              body_wide_i,
  input  logic [WAIT_W-1:0] wait_i,
  input  logic [1:0]        size_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              sck_o,
  output logic              ce_n_o,
  input  logic [3:0]        din_i,
  output logic [3:0]        dout_o,
  output logic [3:0]        douten_o
);

  localparam int unsigned NBYTES    = DATA_W / 8;
  localparam int unsigned MAX_BEATS = (DATA_W > (1 << WAIT_W)) ? DATA_W : (1 << WAIT_W);
  localparam int unsigned CNT_W     = $clog2(MAX_BEATS + 1);
  localparam int unsigned NB_W      = $clog2(NBYTES + 1);

  phase_e              ph_q;
  logic                sck_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [DATA_W-1:0]   tx_q, rx_q, wdata_q;
  logic [ADDR_W-1:0]   addr_q;
  logic                has_addr_q, write_q, cmd_wide_q, body_wide_q;
  logic [WAIT_W-1:0]   wait_q;
  logic [NB_W-1:0]     nbytes_q, nbytes_d;

  always_comb begin
    unique case (size_i)
      2'd0:    nbytes_d = NB_W'(1);
      2'd1:    nbytes_d = NB_W'(2);
      default: nbytes_d = NB_W'(4);
    endcase
  end

  // lowest byte at the top of the stream so it leaves first
  logic [DATA_W-1:0] stream;
  for (genvar b = 0; b < NBYTES; b++) begin : g_stream
    assign stream[DATA_W-1-8*b -: 8] = wdata_q[8*b +: 8];
  end

  logic [CNT_W-1:0] data_beats;
  assign data_beats = body_wide_q ? CNT_W'({nbytes_q, 1'b0}) : CNT_W'({nbytes_q, 3'b000});

  logic active, cur_wide, driving;
  assign active   = (ph_q == PH_CMD) || (ph_q == PH_ADDR) || (ph_q == PH_DUMMY) || (ph_q == PH_DATA);
  assign cur_wide = (ph_q == PH_CMD) ? cmd_wide_q : body_wide_q;
  assign driving  = (ph_q == PH_CMD) || (ph_q == PH_ADDR) || (ph_q == PH_DATA && write_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q        <= PH_IDLE;
      sck_q       <= 1'b0;
      cnt_q       <= '0;
      tx_q        <= '0;
      rx_q        <= '0;
      wdata_q     <= '0;
      addr_q      <= '0;
      has_addr_q  <= 1'b0;
      write_q     <= 1'b0;
      cmd_wide_q  <= 1'b0;
      body_wide_q <= 1'b0;
      wait_q      <= '0;
      nbytes_q    <= '0;
    end else if (ph_q == PH_IDLE) begin
      if (start_i) begin
        ph_q        <= PH_CMD;
        sck_q       <= 1'b0;
        cnt_q       <= cmd_wide_i ? CNT_W'(2) : CNT_W'(8);
        tx_q        <= {op_i, (DATA_W-8)'(0)};
        rx_q        <= '0;
        wdata_q     <= wdata_i;
        addr_q      <= addr_i;
        has_addr_q  <= has_addr_i;
        write_q     <= write_i;
        cmd_wide_q  <= cmd_wide_i;
        body_wide_q <= body_wide_i;
        wait_q      <= wait_i;
        nbytes_q    <= nbytes_d;
      end
    end else if (ph_q == PH_END) begin
      ph_q <= PH_IDLE;
    end else if (active) begin
      if (!sck_q) begin
        sck_q <= 1'b1;
      end else begin
        sck_q <= 1'b0;
        tx_q  <= cur_wide ? {tx_q[DATA_W-5:0], 4'b0000} : {tx_q[DATA_W-2:0], 1'b0};
        if (ph_q == PH_DATA && !write_q)
          rx_q <= body_wide_q ? {rx_q[DATA_W-5:0], din_i} : {rx_q[DATA_W-2:0], din_i[1]};
        if (cnt_q != CNT_W'(1)) begin
          cnt_q <= cnt_q - CNT_W'(1);
        end else begin
          unique case (ph_q)
            PH_CMD: begin
              if (has_addr_q) begin
                ph_q  <= PH_ADDR;
                cnt_q <= body_wide_q ? CNT_W'(ADDR_W / 4) : CNT_W'(ADDR_W);
                tx_q  <= {addr_q, (DATA_W-ADDR_W)'(0)};
              end else begin
                ph_q <= PH_END;
              end
            end
            PH_ADDR: begin
              if (!write_q && wait_q != '0) begin
                ph_q  <= PH_DUMMY;
                cnt_q <= CNT_W'(wait_q);
              end else begin
                ph_q  <= PH_DATA;
                cnt_q <= data_beats;
                tx_q  <= stream;
              end
            end
            PH_DUMMY: begin
              ph_q  <= PH_DATA;
              cnt_q <= data_beats;
              tx_q  <= stream;
            end
            default: ph_q <= PH_END;
          endcase
        end
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int b = 0; b < NBYTES; b++) begin
      if (b < int'(nbytes_q)) rdata_o[8*b +: 8] = rx_q[8*(int'(nbytes_q)-1-b) +: 8];
    end
  end

  assign busy_o   = (ph_q != PH_IDLE);
  assign done_o   = (ph_q == PH_END);
  assign sck_o    = sck_q;
  assign ce_n_o   = (ph_q == PH_IDLE) || (ph_q == PH_END);
  assign dout_o   = !driving ? 4'b0000 : (cur_wide ? tx_q[DATA_W-1 -: 4] : {3'b000, tx_q[DATA_W-1]});
  assign douten_o = !driving ? 4'b0000 : (cur_wide ? 4'b1111 : 4'b0001);

endmodule

// File: rtl/psram_front.sv
module psram_front
  import psram_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned WAIT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_valid_i,
  input  logic              bus_write_i,
  input  logic [31:0]       bus_addr_i,
  input  logic [1:0]        bus_size_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              bus_ready_o,
  // configuration side
  output logic              cfg_we_o,
  output logic [2:0]        cfg_slot_o,
  output logic              qpi_set_o,
  output logic              qpi_clr_o,
  input  logic [7:0]        rd_op_i,
  input  logic [7:0]        wr_op_i,
  input  logic [7:0]        eq_op_i,
  input  logic [7:0]        xq_op_i,
  input  logic [1:0]        mode_i,
  // engine side
  output logic              start_o,
  output logic [7:0]        op_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              has_addr_o,
  output logic              cmd_wide_o,
  output logic              body_wide_o,
  input  logic              done_i,
  input  logic [DATA_W-1:0] eng_rdata_i
);

  logic busy_q, rd_pend_q, enter_pend_q, exit_pend_q;
  logic [DATA_W-1:0] rdata_q;

  logic win_data, win_cfg, accept, cfg_wr, trig_enter, trig_exit, data_go;
  assign win_data   = (bus_addr_i[31:27] == WIN_DATA);
  assign win_cfg    = (bus_addr_i[31:27] == WIN_CFG);
  assign accept     = bus_valid_i && !busy_q;
  assign cfg_slot_o = bus_addr_i[4:2];
  assign cfg_wr     = accept && win_cfg && bus_write_i;
  assign trig_enter = cfg_wr && (cfg_slot_o == SLOT_ENTER);
  assign trig_exit  = cfg_wr && (cfg_slot_o == SLOT_EXIT);
  assign cfg_we_o   = cfg_wr && !trig_enter && !trig_exit;
  assign data_go    = accept && win_data;

  assign start_o     = data_go || trig_enter || trig_exit;
  assign has_addr_o  = data_go;
  assign addr_o      = bus_addr_i[ADDR_W-1:0];
  assign op_o        = trig_enter ? eq_op_i :
                       trig_exit  ? xq_op_i :
                       bus_write_i ? wr_op_i : rd_op_i;
  // enter-quad always one lane, leave-quad always four lanes
  assign cmd_wide_o  = trig_exit || (!trig_enter && mode_i[1]);
  assign body_wide_o = mode_i[1] || mode_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q       <= 1'b0;
      rd_pend_q    <= 1'b0;
      enter_pend_q <= 1'b0;
      exit_pend_q  <= 1'b0;
      rdata_q      <= '0;
    end else if (start_o) begin
      busy_q       <= 1'b1;
      rd_pend_q    <= data_go && !bus_write_i;
      enter_pend_q <= trig_enter;
      exit_pend_q  <= trig_exit;
    end else if (done_i) begin
      busy_q       <= 1'b0;
      rd_pend_q    <= 1'b0;
      enter_pend_q <= 1'b0;
      exit_pend_q  <= 1'b0;
      if (rd_pend_q) rdata_q <= eng_rdata_i;
    end
  end

  assign qpi_set_o   = done_i && enter_pend_q;
  assign qpi_clr_o   = done_i && exit_pend_q;
  assign bus_ready_o = !busy_q;
  assign bus_rdata_o = rdata_q;

endmodule

// File: rtl/psram_ctrl.sv
module psram_ctrl
  import psram_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned WAIT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_valid_i,
  input  logic              bus_write_i,
  input  logic [31:0]       bus_addr_i,
  input  logic [1:0]        bus_size_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              bus_ready_o,
  output logic              sck_o,
  output logic              ce_n_o,
  input  logic [3:0]        din_i,
  output logic [3:0]        dout_o,
  output logic [3:0]        douten_o
);

  logic              cfg_we, qpi_set, qpi_clr;
  logic [2:0]        cfg_slot;
  logic [7:0]        rd_op, wr_op, eq_op, xq_op, op;
  logic [WAIT_W-1:0] wait_cnt;
  logic [1:0]        mode;
  logic              start, has_addr, cmd_wide, body_wide, busy, done;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] eng_rdata;

  psram_cfg #(.WAIT_W(WAIT_W)) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (cfg_we),
    .slot_i    (cfg_slot),
    .wdata_i   (bus_wdata_i[31:0]),
    .qpi_set_i (qpi_set),
    .qpi_clr_i (qpi_clr),
    .rd_op_o   (rd_op),
    .wr_op_o   (wr_op),
    .eq_op_o   (eq_op),
    .xq_op_o   (xq_op),
    .wait_o    (wait_cnt),
    .mode_o    (mode)
  );

  psram_front #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .WAIT_W(WAIT_W)) u_front (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_valid_i (bus_valid_i),
    .bus_write_i (bus_write_i),
    .bus_addr_i  (bus_addr_i),
    .bus_size_i  (bus_size_i),
    .bus_rdata_o (bus_rdata_o),
    .bus_ready_o (bus_ready_o),
    .cfg_we_o    (cfg_we),
    .cfg_slot_o  (cfg_slot),
    .qpi_set_o   (qpi_set),
    .qpi_clr_o   (qpi_clr),
    .rd_op_i     (rd_op),
    .wr_op_i     (wr_op),
    .eq_op_i     (eq_op),
    .xq_op_i     (xq_op),
    .mode_i      (mode),
    .start_o     (start),
    .op_o        (op),
    .addr_o      (addr),
    .has_addr_o  (has_addr),
    .cmd_wide_o  (cmd_wide),
    .body_wide_o (body_wide),
    .done_i      (done),
    .eng_rdata_i (eng_rdata)
  );

  psram_engine #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .WAIT_W(WAIT_W)) u_engine (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .op_i        (op),
    .addr_i      (addr),
    .has_addr_i  (has_addr),
    .write_i     (bus_write_i),
    .cmd_wide_i  (cmd_wide),
    .body_wide_i (body_wide),
    .wait_i      (wait_cnt),
    .size_i      (bus_size_i),
    .wdata_i     (bus_wdata_i),
    .busy_o      (busy),
    .done_o      (done),
    .rdata_o     (eng_rdata),
    .sck_o       (sck_o),
    .ce_n_o      (ce_n_o),
    .din_i       (din_i),
    .dout_o      (dout_o),
    .douten_o    (douten_o)
  );

endmodule

// File: rtl/psram_ctrl_chk.sv
module psram_ctrl_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        bus_valid_i,
  input logic        bus_write_i,
  input logic [31:0] bus_addr_i,
  input logic        bus_ready_o,
  input logic        sck_o,
  input logic        ce_n_o,
  input logic [3:0]  douten_o
);

  // R13
  a_r13_sck_low_deselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_n_o |-> !sck_o);

  // R12
  a_r12_no_drive_deselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_n_o |-> douten_o == 4'b0000);

  // R12
  a_r12_lane_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    douten_o == 4'b0000 || douten_o == 4'b0001 || douten_o == 4'b1111);

  // R10
  a_r10_stall_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_n_o |-> !bus_ready_o);

  // R10
  a_r10_data_accept_stalls: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_i && bus_ready_o && bus_addr_i[31:27] == 5'b00000) |=> !bus_ready_o);

  // R2
  a_r2_cfg_write_no_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_i && bus_ready_o && bus_write_i && bus_addr_i[31:27] == 5'b00001
     && bus_addr_i[4:2] < 3'd6) |=> (ce_n_o && bus_ready_o));

endmodule

bind psram_ctrl psram_ctrl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_valid_i (bus_valid_i),
  .bus_write_i (bus_write_i),
  .bus_addr_i  (bus_addr_i),
  .bus_ready_o (bus_ready_o),
  .sck_o       (sck_o),
  .ce_n_o      (ce_n_o),
  .douten_o    (douten_o)
);

// File: tb/tb_psram_ctrl.sv
`timescale 1ns/1ps
module tb_psram_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0, write = 1'b0;
  logic [31:0] addr = '0, wdata = '0;
  logic [1:0]  size = 2'd2;
  logic [31:0] rdata;
  logic        ready, sck, ce_n;
  logic [3:0]  din = 4'b0000, dout, douten;

  always #2.5 clk = ~clk;

  psram_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_valid_i(valid), .bus_write_i(write),
    .bus_addr_i(addr), .bus_size_i(size), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .bus_ready_o(ready), .sck_o(sck), .ce_n_o(ce_n), .din_i(din), .dout_o(dout),
    .douten_o(douten)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // ---------------- memory model ----------------
  logic [7:0] mem [256];
  bit         m_qpi = 0, m_qspi = 0;
  logic [7:0] m_rd_op = 8'h03, m_wr_op = 8'h02, m_eq_op = 8'h35, m_xq_op = 8'hFE;
  int         m_wait = 0;
  int         frames = 0, beats = 0, bits = 0, dcnt = 0, wpos = 0, rpos = 0;
  logic [7:0] op = '0, wsh = '0;
  logic [23:0] maddr = '0;
  logic [3:0] cmd_oe = '0, body_oe = '0, rd_oe = '0;
  int         last_beats = 0;
  logic [7:0] last_op = '0;

  always @(negedge ce_n) begin
    frames++; beats = 0; bits = 0; dcnt = 0; wpos = 0; rpos = 0; op = '0; maddr = '0;
  end

  always @(posedge ce_n) begin
    last_beats = beats; last_op = op;
    if (bits == 8 && op == m_eq_op && !m_qpi) m_qpi = 1;
    else if (bits == 8 && op == m_xq_op && m_qpi) m_qpi = 0;
  end

  always @(posedge sck) begin
    if (!ce_n) begin
      int cw, bw;
      cw = m_qpi ? 4 : 1;
      bw = (m_qpi || m_qspi) ? 4 : 1;
      beats++;
      if (bits < 8) begin
        if (bits == 0) cmd_oe = douten;
        op = (cw == 4) ? {op[3:0], dout} : {op[6:0], dout[0]};
        bits += cw;
      end else if (bits < 32) begin
        if (bits == 8) body_oe = douten;
        maddr = (bw == 4) ? {maddr[19:0], dout} : {maddr[22:0], dout[0]};
        bits += bw;
      end else if (op == m_wr_op) begin
        wsh = (bw == 4) ? {wsh[3:0], dout} : {wsh[6:0], dout[0]};
        bits += bw;
        if (((bits - 32) % 8) == 0) begin
          mem[8'(maddr) + 8'(wpos)] = wsh;
          wpos++;
        end
      end else if (op == m_rd_op) begin
        if (dcnt < m_wait) dcnt++;
        else rd_oe = douten;
      end
    end
  end

  always @(negedge sck) begin
    if (!ce_n && bits >= 32 && op == m_rd_op && dcnt >= m_wait) begin
      logic [7:0] byt;
      int bw;
      bw  = (m_qpi || m_qspi) ? 4 : 1;
      byt = mem[8'(maddr) + 8'(rpos / 8)];
      #1;
      if (bw == 4) din = ((rpos % 8) == 0) ? byt[7:4] : byt[3:0];
      else         din = {2'b00, byt[7 - (rpos % 8)], 1'b0};
      rpos += bw;
    end
  end

  // ---------------- bus driver ----------------
  int stall;

  task automatic access(input bit wr, input logic [31:0] a, input logic [1:0] sz,
                        input logic [31:0] d);
    while (!ready) @(negedge clk);
    valid = 1'b1; write = wr; addr = a; size = sz; wdata = d;
    @(negedge clk);
    valid = 1'b0;
    stall = 0;
    while (!ready) begin
      stall++;
      @(negedge clk);
    end
  endtask

  function automatic logic [31:0] cfg(input int slot);
    return 32'h0800_0000 | (slot << 2);
  endfunction

  // ---------------- scenarios ----------------
  task automatic t_reset();
    check("R1 ce_n", 32'(ce_n), 32'h1);
    check("R1 sck", 32'(sck), 32'h0);
    check("R1 douten", 32'(douten), 32'h0);
    check("R1 ready", 32'(ready), 32'h1);
  endtask

  task automatic t_spi_word();
    access(1, 32'h0000_0010, 2'd2, 32'h1122_3344);
    check("R3 write opcode", 32'(last_op), 32'h02);
    check("R3 write edges", 32'(last_beats), 32'd64);
    check("R10 write stall", 32'(stall), 32'd129);
    check("R11 byte0 at low addr", 32'(mem[8'h10]), 32'h44);
    check("R11 byte3", 32'(mem[8'h13]), 32'h11);
    check("R12 single-lane cmd oe", 32'(cmd_oe), 32'h1);
    access(0, 32'h0000_0010, 2'd2, 32'h0);
    check("R3 read opcode", 32'(last_op), 32'h03);
    check("R3 read data", rdata, 32'h1122_3344);
    check("R12 read data oe off", 32'(rd_oe), 32'h0);
  endtask

  task automatic t_sizes();
    mem[8'h22] = 8'h77;
    access(1, 32'h0000_0021, 2'd0, 32'hFFFF_FFAB);
    check("R11 byte write", 32'(mem[8'h21]), 32'hAB);
    check("R11 byte neighbour", 32'(mem[8'h22]), 32'h77);
    check("R11 byte edges", 32'(last_beats), 32'd40);
    access(1, 32'h0000_0030, 2'd1, 32'h0000_BEEF);
    check("R11 half low", 32'(mem[8'h30]), 32'hEF);
    check("R11 half high", 32'(mem[8'h31]), 32'hBE);
    access(0, 32'h0000_0031, 2'd0, 32'h0);
    check("R11 byte read", rdata, 32'h0000_00BE);
    access(0, 32'h0000_0030, 2'd1, 32'h0);
    check("R11 half read", rdata, 32'h0000_BEEF);
  endtask

  task automatic t_decode();
    int f0;
    f0 = frames;
    access(1, cfg(4), 2'd2, 32'h0);
    check("R2 cfg write no stall", 32'(stall), 32'd0);
    access(0, cfg(0), 2'd2, 32'h0);
    access(1, 32'h1000_0000, 2'd2, 32'h5);
    access(0, 32'h2000_0040, 2'd2, 32'h0);
    repeat (4) @(negedge clk);
    check("R2 no frame outside data window", 32'(frames - f0), 32'd0);
  endtask

  task automatic t_opcode_wait();
    mem[8'h50] = 8'hA1; mem[8'h51] = 8'hB2; mem[8'h52] = 8'hC3; mem[8'h53] = 8'hD4;
    access(1, cfg(0), 2'd2, 32'h0000_000B);
    access(1, cfg(4), 2'd2, 32'h0000_0008);
    m_rd_op = 8'h0B; m_wait = 8;
    access(0, 32'h0000_0050, 2'd2, 32'h0);
    check("R4 read opcode programmed", 32'(last_op), 32'h0B);
    check("R5 dummy edges", 32'(last_beats), 32'd72);
    check("R5 read after dummies", rdata, 32'hD4C3_B2A1);
    access(1, 32'h0000_0054, 2'd0, 32'h0000_0066);
    check("R5 no dummies on write", 32'(last_beats), 32'd40);
    access(1, cfg(1), 2'd2, 32'h0000_0012);
    m_wr_op = 8'h12;
    access(1, 32'h0000_0055, 2'd0, 32'h0000_0099);
    check("R4 write opcode programmed", 32'(last_op), 32'h12);
    check("R4 written byte", 32'(mem[8'h55]), 32'h99);
    access(1, cfg(0), 2'd2, 32'h3);
    access(1, cfg(1), 2'd2, 32'h2);
    access(1, cfg(4), 2'd2, 32'h0);
    m_rd_op = 8'h03; m_wr_op = 8'h02; m_wait = 0;
  endtask

  task automatic t_qspi();
    access(1, cfg(5), 2'd2, 32'h1);
    m_qspi = 1;
    access(1, 32'h0000_0040, 2'd2, 32'hCAFE_F00D);
    check("R6 quad-data edges", 32'(last_beats), 32'd22);
    check("R6 cmd single lane", 32'(cmd_oe), 32'h1);
    check("R12 address four lanes", 32'(body_oe), 32'hF);
    check("R6 byte order", 32'(mem[8'h40]), 32'h0D);
    access(0, 32'h0000_0040, 2'd2, 32'h0);
    check("R6 read back", rdata, 32'hCAFE_F00D);
    access(1, cfg(5), 2'd2, 32'h0);
    m_qspi = 0;
  endtask

  task automatic t_qpi();
    access(1, cfg(6), 2'd2, 32'h0);
    check("R8 enter opcode", 32'(last_op), 32'h35);
    check("R8 enter edges", 32'(last_beats), 32'd8);
    check("R8 enter stall", 32'(stall), 32'd17);
    access(1, 32'h0000_0060, 2'd2, 32'h0BAD_BEEF);
    check("R7 quad write edges", 32'(last_beats), 32'd16);
    check("R7 cmd four lanes", 32'(cmd_oe), 32'hF);
    check("R10 quad stall", 32'(stall), 32'd33);
    access(0, 32'h0000_0060, 2'd2, 32'h0);
    check("R7 quad read", rdata, 32'h0BAD_BEEF);
    access(1, cfg(7), 2'd2, 32'h0);
    check("R9 exit opcode", 32'(last_op), 32'hFE);
    check("R9 exit edges", 32'(last_beats), 32'd2);
    access(0, 32'h0000_0010, 2'd2, 32'h0);
    check("R9 single lane again", 32'(last_beats), 32'd64);
    check("R9 read after exit", rdata, 32'h1122_3344);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_spi_word();
    t_sizes();
    t_decode();
    t_opcode_wait();
    t_qspi();
    t_qpi();
    repeat (4) @(negedge clk);
    check("R13 idle after frames", 32'({ce_n, sck}), 32'h2);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule